// File: doc/BRIEF.md
# Attribute-Colour Pixel Serializer

This block turns bitmap bytes and attribute bytes into a stream of 3-bit RGB pixels for character-cell display modes with one bit per pixel. While the pixel window input is high, the block emits one pixel per clock. A separate fetch unit delivers the bytes in fixed slots ahead of the column that needs them. Each bitmap byte covers one character column of 8 pixels, sent most significant bit first. Each pixel can be held for one, two or three clocks.

A line opens with a short dark lead-in, so the fetch unit can supply column 0's data first. Colour comes from one of three modes. In plain two-level mode, bit 1 gives white and bit 0 gives black. In whole-byte mode, one attribute byte serves each column. In shared mode, one attribute byte serves two neighbouring columns, one nibble each. Attribute bytes are taken in only on the first pixel row of a character row. They are kept in a column-indexed store and reused for the seven rows below.

Top module: `acs_serializer`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, `rgb` is 000.
- R2: `rgb` is 000 in the cycle after any cycle with `win_en` low, and for the first LEAD (8) window cycles of each line. The window cycle count restarts each time `win_en` goes high.
- R3: With `scale_sel`=0 (x1), each bitmap byte gives 8 pixels of one clock each, bit 7 first and bit 0 last.
- R4: With `scale_sel`=1 (x2), each pixel lasts 2 clocks. With `scale_sel`=2 (x3), each pixel lasts 3 clocks. Columns therefore span 16 or 24 clocks.
- R5: A line has 80, 40 or 26 columns for x1, x2 or x3. Once the last column is done, `rgb` is 000 until the window closes.
- R6: With `attr_mode`=0, a 1 bit gives 111 and a 0 bit gives 000.
- R7: With `attr_mode`=1, column k takes the k-th attribute byte of its first-row line. Bits 6:4 give the colour of 1 bits and bits 2:0 give the colour of 0 bits.
- R8: With `attr_mode`=2, attribute byte j serves columns 2j and 2j+1. The even column uses bits 7:4 and the odd column uses bits 3:0. Within a nibble, bits 3:2 pick the 1-bit colour and bits 1:0 pick the 0-bit colour, from the table 0→000, 1→100, 2→110, 3→111.
- R9: Attribute bytes are stored only while `row_in_char` is 0. The n-th byte of a line goes to entry n, up to 40 entries. Bytes offered on rows 1 to 7 are ignored, and those rows reuse the stored entries.
- R10: A column uses the bitmap byte most recently offered with `bm_vld` before that column's first pixel cycle.
- R11: The pixel for window cycle n appears on `rgb` in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Pixel window of the current line |
| scale_sel | input | 2 | Pixel scaling: 0 x1, 1 x2, 2 x3 (3 acts as x1) |
| attr_mode | input | 2 | Colour mode: 0 two-level, 1 whole byte, 2 shared nibble (3 acts as 0) |
| row_in_char | input | 3 | Pixel row within the character row |
| bm_vld | input | 1 | Bitmap byte offered this cycle |
| bm_byte | input | 8 | Bitmap byte |
| at_vld | input | 1 | Attribute byte offered this cycle |
| at_byte | input | 8 | Attribute byte |
| rgb | output | 3 | Pixel colour, red in bit 2, blue in bit 0 |

## Verification
The bench uses the default parameters: an 8-cycle lead-in, column limits of 80, 40 and 26, and a 40-entry attribute store. With these values the x3 line ends eight pad cycles before 640 clocks. Each mode's column limit and trailing pad are therefore reached within one short line. The 40-column whole-byte line fills every store entry. Lines with a non-zero row follow first-row lines of the same mode, so ignored attribute bytes show up as wrong colours across every column.

// File: rtl/acs_pkg.sv
package acs_pkg;

   typedef enum logic [1:0] {
      SCL_X1  = 2'd0,
      SCL_X2  = 2'd1,
      SCL_X3  = 2'd2,
      SCL_RSV = 2'd3
   } scale_e;

   typedef enum logic [1:0] {
      ATR_MONO = 2'd0,
      ATR_BYTE = 2'd1,
      ATR_NIB  = 2'd2,
      ATR_RSV  = 2'd3
   } atr_e;

   localparam int PIX_PER_BYTE = 8;

   // fixed four-colour table used by shared-nibble attributes
   function automatic logic [2:0] nib_rgb(input logic [1:0] code);
      case (code)
         2'd0:    nib_rgb = 3'b000;
         2'd1:    nib_rgb = 3'b100;
         2'd2:    nib_rgb = 3'b110;
         default: nib_rgb = 3'b111;
      endcase
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      max3 = (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/acs_beat.sv
module acs_beat
   import acs_pkg::*;
#(
   parameter int LEAD    = 8,
   parameter int COLS_X1 = 80,
   parameter int COLS_X2 = 40,
   parameter int COLS_X3 = 26,
   parameter int COL_W   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_en,
   input  logic [1:0]       scale_sel,
   output logic [COL_W-1:0] col,
   output logic [2:0]       pix,
   output logic             active,
   output logic             col_first
);

   localparam int LEAD_W = $clog2(LEAD + 1);

   logic [LEAD_W-1:0] lead_q;
   logic [1:0]        sub_q;
   logic [1:0]        sub_last;
   logic [2:0]        pix_q;
   logic [COL_W-1:0]  col_q;
   logic [COL_W-1:0]  ncol;
   logic              body;

   always_comb begin
      case (scale_e'(scale_sel))
         SCL_X2: begin
            sub_last = 2'd1;
            ncol     = COL_W'(COLS_X2);
         end
         SCL_X3: begin
            sub_last = 2'd2;
            ncol     = COL_W'(COLS_X3);
         end
         default: begin
            sub_last = 2'd0;
            ncol     = COL_W'(COLS_X1);
         end
      endcase
   end

   assign body      = win_en && (lead_q == LEAD_W'(LEAD));
   assign active    = body && (col_q < ncol);
   assign col_first = active && (sub_q == 2'd0) && (pix_q == 3'd0);
   assign col       = col_q;
   assign pix       = pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= '0;
         sub_q  <= '0;
         pix_q  <= '0;
         col_q  <= '0;
      end else if (!win_en) begin
         lead_q <= '0;
         sub_q  <= '0;
         pix_q  <= '0;
         col_q  <= '0;
      end else if (!body) begin
         lead_q <= lead_q + LEAD_W'(1);
      end else if (active) begin
         if (sub_q == sub_last) begin
            sub_q <= 2'd0;
            pix_q <= pix_q + 3'd1;
            if (pix_q == 3'd7)
               col_q <= col_q + COL_W'(1);
         end else begin
            sub_q <= sub_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/acs_bits.sv
module acs_bits (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bm_vld,
   input  logic [7:0] bm_byte,
   input  logic       col_first,
   input  logic [2:0] pix,
   output logic       pix_bit
);

   logic [7:0] pend_q;
   logic [7:0] hold_q;
   logic [7:0] cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         hold_q <= '0;
      end else begin
         if (bm_vld)
            pend_q <= bm_byte;
         if (col_first)
            hold_q <= pend_q;
      end
   end

   // the staged byte is used directly in a column's first cycle
   assign cur     = col_first ? pend_q : hold_q;
   assign pix_bit = cur[3'd7 - pix];

endmodule

// File: rtl/acs_attr.sv
module acs_attr
   import acs_pkg::*;
#(
   parameter int DEPTH = 40,
   parameter int COL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_en,
   input  logic [2:0]       row_in_char,
   input  logic             at_vld,
   input  logic [7:0]       at_byte,
   input  logic [1:0]       attr_mode,
   input  logic [COL_W-1:0] col,
   input  logic             pix_bit,
   output logic [2:0]       colour
);

   localparam int PTR_W = $clog2(DEPTH + 1);

   logic [PTR_W-1:0] wptr_q;
   logic             wr_ok;
   logic [7:0]       ent [DEPTH];
   logic [COL_W-1:0] rd_idx;
   logic [7:0]       rd;
   logic [3:0]       nib;

   assign wr_ok = at_vld && (row_in_char == 3'd0) && (wptr_q < PTR_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wptr_q <= '0;
      else if (!win_en)
         wptr_q <= '0;
      else if (wr_ok)
         wptr_q <= wptr_q + PTR_W'(1);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_ok && (wptr_q == PTR_W'(g)))
            q <= at_byte;
      end
      assign ent[g] = q;
   end

   assign rd_idx = (atr_e'(attr_mode) == ATR_NIB) ? (col >> 1) : col;

   always_comb begin
      rd = 8'h00;
      for (int i = 0; i < DEPTH; i++)
         if (int'(rd_idx) == i)
            rd = ent[i];
   end

   assign nib = col[0] ? rd[3:0] : rd[7:4];

   always_comb begin
      case (atr_e'(attr_mode))
         ATR_BYTE: colour = pix_bit ? rd[6:4] : rd[2:0];
         ATR_NIB:  colour = pix_bit ? nib_rgb(nib[3:2]) : nib_rgb(nib[1:0]);
         default:  colour = pix_bit ? 3'b111 : 3'b000;
      endcase
   end

endmodule

// File: rtl/acs_serializer.sv
module acs_serializer
   import acs_pkg::*;
#(
   parameter int LEAD       = 8,
   parameter int COLS_X1    = 80,
   parameter int COLS_X2    = 40,
   parameter int COLS_X3    = 26,
   parameter int ATTR_DEPTH = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       win_en,
   input  logic [1:0] scale_sel,
   input  logic [1:0] attr_mode,
   input  logic [2:0] row_in_char,
   input  logic       bm_vld,
   input  logic [7:0] bm_byte,
   input  logic       at_vld,
   input  logic [7:0] at_byte,
   output logic [2:0] rgb
);

   localparam int COL_MAX = max3(COLS_X1, COLS_X2, COLS_X3);
   localparam int COL_W   = $clog2(COL_MAX + 1);

   if (LEAD < 1) begin : g_bad_lead
      $error("acs_serializer: LEAD must be at least 1");
   end
   if (ATTR_DEPTH < COLS_X2) begin : g_bad_depth
      $error("acs_serializer: ATTR_DEPTH must cover the x2 column count");
   end
   if (COLS_X1 < 1 || COLS_X2 < 1 || COLS_X3 < 1) begin : g_bad_cols
      $error("acs_serializer: column counts must be positive");
   end

   logic [COL_W-1:0] col;
   logic [2:0]       pix;
   logic             active;
   logic             col_first;
   logic             pix_bit;
   logic [2:0]       colour;
   logic [2:0]       rgb_q;

   acs_beat #(
      .LEAD    (LEAD),
      .COLS_X1 (COLS_X1),
      .COLS_X2 (COLS_X2),
      .COLS_X3 (COLS_X3),
      .COL_W   (COL_W)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_en    (win_en),
      .scale_sel (scale_sel),
      .col       (col),
      .pix       (pix),
      .active    (active),
      .col_first (col_first)
   );

   acs_bits u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .bm_vld    (bm_vld),
      .bm_byte   (bm_byte),
      .col_first (col_first),
      .pix       (pix),
      .pix_bit   (pix_bit)
   );

   acs_attr #(
      .DEPTH (ATTR_DEPTH),
      .COL_W (COL_W)
   ) u_attr (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_en      (win_en),
      .row_in_char (row_in_char),
      .at_vld      (at_vld),
      .at_byte     (at_byte),
      .attr_mode   (attr_mode),
      .col         (col),
      .pix_bit     (pix_bit),
      .colour      (colour)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rgb_q <= 3'b000;
      else
         rgb_q <= active ? colour : 3'b000;
   end

   assign rgb = rgb_q;

endmodule

// File: rtl/acs_serializer_chk.sv
module acs_serializer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       win_en,
   input logic [1:0] attr_mode,
   input logic [2:0] rgb
);

   // R2
   closed_window_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |=> (rgb == 3'b000));

   // R2
   lead_in_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_en) |=> (rgb == 3'b000));

   // R6
   two_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_mode == 2'd0) |=> (rgb == 3'b000 || rgb == 3'b111));

   // R8
   nibble_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_mode == 2'd2) |=> (rgb == 3'b000 || rgb == 3'b100 ||
                               rgb == 3'b110 || rgb == 3'b111));

endmodule

bind acs_serializer acs_serializer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .win_en    (win_en),
   .attr_mode (attr_mode),
   .rgb       (rgb)
);

// File: tb/acs_serializer_tb.sv
module acs_serializer_tb;

   localparam int CLK_NS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       win_en = 1'b0;
   logic [1:0] scale_sel = 2'd0;
   logic [1:0] attr_mode = 2'd0;
   logic [2:0] row_in_char = 3'd0;
   logic       bm_vld = 1'b0;
   logic [7:0] bm_byte = 8'h00;
   logic       at_vld = 1'b0;
   logic [7:0] at_byte = 8'h00;
   logic [2:0] rgb;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [7:0] bm [80];
   logic [7:0] at [80];
   logic [7:0] abuf [40];
   logic [2:0] exp_prev = 3'b000;
   string      tag_prev = "R1";

   always #(CLK_NS/2) clk = ~clk;

   acs_serializer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_en      (win_en),
      .scale_sel   (scale_sel),
      .attr_mode   (attr_mode),
      .row_in_char (row_in_char),
      .bm_vld      (bm_vld),
      .bm_byte     (bm_byte),
      .at_vld      (at_vld),
      .at_byte     (at_byte),
      .rgb         (rgb)
   );

   task automatic check(input logic [2:0] e, input string tag);
      total++;
      if (rgb !== e) begin
         bad++;
         $display("FAIL %s: rgb=%b expected=%b at %0t", tag, rgb, e, $time);
      end
   endtask

   function automatic logic [2:0] tbl(input int v);
      case (v)
         0: tbl = 3'b000;
         1: tbl = 3'b100;
         2: tbl = 3'b110;
         default: tbl = 3'b111;
      endcase
   endfunction

   // one full line; the model predicts each window cycle and compares one cycle later (R11)
   task automatic run_line(input int sc, input int am, input int row, input int seed);
      int s, len, nc, wlen;
      s    = sc + 1;
      len  = 8 * s;
      nc   = (sc == 0) ? 80 : (sc == 1) ? 40 : 26;
      wlen = 8 + nc * len + 8;
      for (int k = 0; k < 80; k++) begin
         bm[k] = 8'(seed * 37 + k * 53 + 11);
         at[k] = 8'(seed * 91 + k * 29 + 5);
      end
      scale_sel   = 2'(sc);
      attr_mode   = 2'(am);
      row_in_char = 3'(row);
      for (int n = 0; n < wlen; n++) begin
         int off, k, c, pix, b, a, nib;
         logic [2:0] e;
         string t;
         @(negedge clk);
         check(exp_prev, tag_prev);
         win_en = 1'b1;
         bm_vld = 1'b0;
         at_vld = 1'b0;
         if (n < 8) begin
            off = n;
            k   = 0;
         end else begin
            off = (n - 8) % len;
            k   = (n - 8) / len + 1;
         end
         if (k < nc) begin
            // R10: a stale byte first, the byte to show after it
            if (off == 1) begin
               bm_vld  = 1'b1;
               bm_byte = ~bm[k];
            end
            if (off == 2) begin
               bm_vld  = 1'b1;
               bm_byte = bm[k];
            end
            if (off == 4 && (am == 1 || (am == 2 && (k % 2) == 0))) begin
               int idx;
               idx     = (am == 1) ? k : k / 2;
               at_vld  = 1'b1;
               at_byte = (row == 0) ? at[idx] : ~at[idx];
               if (row == 0 && idx < 40)
                  abuf[idx] = at[idx];
            end
         end
         if (n < 8) begin
            e = 3'b000;
            t = "R2";
         end else if ((n - 8) >= nc * len) begin
            e = 3'b000;
            t = "R5";
         end else begin
            c   = (n - 8) / len;
            pix = ((n - 8) % len) / s;
            b   = bm[c][7 - pix];
            if (am == 1) begin
               a = (c < 40) ? abuf[c] : 0;
               e = (b != 0) ? 3'(a >> 4) : 3'(a);
               t = "R7";
            end else if (am == 2) begin
               a   = abuf[c / 2];
               nib = (c % 2 == 1) ? (a & 15) : ((a >> 4) & 15);
               e   = (b != 0) ? tbl(nib >> 2) : tbl(nib & 3);
               t   = "R8";
            end else begin
               e = (b != 0) ? 3'b111 : 3'b000;
               t = (sc == 0) ? "R3" : "R4";
            end
            if (row != 0 && am != 0)
               t = "R9";
         end
         exp_prev = e;
         tag_prev = t;
      end
      for (int g = 0; g < 4; g++) begin
         @(negedge clk);
         check(exp_prev, tag_prev);
         win_en   = 1'b0;
         bm_vld   = 1'b0;
         at_vld   = 1'b0;
         exp_prev = 3'b000;
         tag_prev = "R2";
      end
   endtask

   initial begin
      for (int i = 0; i < 40; i++)
         abuf[i] = 8'h00;
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check(3'b000, "R1");
      end
      rst_n = 1'b1;
      @(negedge clk);
      check(3'b000, "R1");
      run_line(0, 0, 0, 1);  // R3, R6: x1 two-level
      run_line(1, 1, 0, 2);  // R4, R7: x2 whole-byte attributes, first row
      run_line(1, 1, 3, 3);  // R9: later row ignores offered attributes
      run_line(2, 2, 0, 4);  // R4, R5, R8: x3 shared nibbles with trailing pad
      run_line(2, 2, 5, 5);  // R9: later row, nibble mode
      run_line(1, 0, 1, 6);  // R4, R6: x2 two-level
      run_line(2, 1, 0, 7);  // R4, R5, R7: x3 whole-byte attributes
      run_line(0, 0, 2, 8);  // R3, R10: x1 again after other modes
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule